// File: doc/BRIEF.md
# Single-Wire Bus Master with Identity Fetch

This block drives one open-drain single-wire serial line with a pull-up. It never drives the line high. It either pulls the line low or lets it go. A host gives it one of four commands through a valid/opcode/data strobe:

- a bus reset with presence detection;
- a byte write;
- a byte read;
- an identity fetch, which chains a reset, the identity-read command byte and eight byte reads.

All slot timing comes from a microsecond tick. The tick is divided down from the system clock by the `CLK_MHZ` parameter and is restarted at the start of every slot, so each slot phase lasts an exact number of clock cycles.

The returned line level passes through a synchronizer before it is sampled. Results leave the block in four places:

- a one-cycle read strobe with its byte;
- a presence flag;
- three identity registers: family byte, 48-bit serial number and check byte;
- a one-cycle done pulse that closes every command.

While a command runs, the block shows busy and takes no new command.

Top module: `ow_master`

## Requirements
- R1: After reset the line is released (`ow_drive_low`=0), and `busy`, `done`, `rd_valid`, `presence`, `rd_data` and all identity outputs are 0.
- R2: A bus-reset command (`cmd_op`=0) pulls the line low for exactly 480 us, which is 480*CLK_MHZ cycles. It samples the line 70 us after release and holds off a further 410 us. `busy` stays high for 960*CLK_MHZ+2 cycles from the accepting edge.
- R3: `presence` is set to 1 when the line sampled 70 us after reset release is low, and cleared to 0 when it is high. A responder that lets go before that instant therefore reads as absent.
- R4: A write command (`cmd_op`=1) sends `cmd_data` bit 0 first. A 1 bit is a 6 us low pulse followed by 64 us released. A 0 bit is a 60 us low pulse followed by 10 us released.
- R5: A read command (`cmd_op`=2) runs eight slots. Each slot pulls the line low for 6 us, then samples it 9 us after release and ends 55 us later. Each sample enters at bit 7 while earlier bits move right, so the first bit on the wire lands in bit 0. `rd_data` is presented with a one-cycle `rd_valid`.
- R6: An identity fetch (`cmd_op`=3) performs a bus reset (updating `presence`), writes 0x33 and reads eight bytes. The first byte goes to `id_family`. The next six go to `id_serial`, earliest in bits 7:0 and the sixth in bits 47:40. The last goes to `id_check`. `rd_valid` does not pulse during the fetch.
- R7: Every accepted command ends with exactly one one-cycle `done` pulse, in the cycle where `busy` has returned low.
- R8: A `cmd_valid` that arrives while `busy` is high is ignored. It adds no slots and no `done` pulse, and it does not alter the running command's result.
- R9: The line is pulled low only while a command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | 0 reset, 1 write byte, 2 read byte, 3 identity fetch |
| cmd_data | input | 8 | Byte to send for a write command |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| ow_in | input | 1 | Line level as seen at the pin (asynchronous) |
| ow_drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` after a read command |
| rd_data | output | 8 | Byte collected by the last read command |
| presence | output | 1 | 1 when a responder answered the last bus reset |
| id_family | output | 8 | First byte of the last identity fetch |
| id_serial | output | 48 | Six serial bytes, earliest in bits 7:0 |
| id_check | output | 8 | Last byte of the identity fetch |

## Verification
On every cycle, the bound checker enforces the following:

- The line is never pulled low while idle.
- A low pulse never grows past the bus-reset length.
- `done` is a lone pulse that coincides with idle.
- `rd_valid` only appears together with `done`.
- `busy` only rises after a strobe.

Some properties cannot be seen cycle by cycle and are shown only by the bench's scenarios:

- the exact low-pulse widths per bit value;
- the bit order on the wire and in assembled bytes;
- the presence sampling instant, probed by responder windows that end just before or begin just before the 70 us point;
- the placement of identity bytes;
- the rejection of a command issued mid-read.

// File: rtl/ow_pkg.sv
package ow_pkg;

  localparam int unsigned RST_LOW_US  = 480;
  localparam int unsigned RST_SAMP_US = 70;
  localparam int unsigned RST_TAIL_US = 410;
  localparam int unsigned W1_LOW_US   = 6;
  localparam int unsigned W1_TAIL_US  = 64;
  localparam int unsigned W0_LOW_US   = 60;
  localparam int unsigned W0_TAIL_US  = 10;
  localparam int unsigned RD_LOW_US   = 6;
  localparam int unsigned RD_SAMP_US  = 9;
  localparam int unsigned RD_TAIL_US  = 55;

  localparam int unsigned US_CNT_W = $clog2(RST_LOW_US + 1);

  localparam logic [7:0]  ROM_READ_CMD = 8'h33;
  localparam int unsigned ROM_LEN      = 8;
  localparam int unsigned ID_BYTES     = 6;

  typedef logic [US_CNT_W-1:0] us_cnt_t;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_ROM   = 2'd3
  } ow_op_e;

  typedef enum logic [1:0] {
    SL_RESET = 2'd0,
    SL_W1    = 2'd1,
    SL_W0    = 2'd2,
    SL_READ  = 2'd3
  } slot_e;

  // Length of the driven-low phase of a slot, in microseconds.
  function automatic us_cnt_t low_us(slot_e k);
    case (k)
      SL_RESET: return us_cnt_t'(RST_LOW_US);
      SL_W1:    return us_cnt_t'(W1_LOW_US);
      SL_W0:    return us_cnt_t'(W0_LOW_US);
      default:  return us_cnt_t'(RD_LOW_US);
    endcase
  endfunction

  // Delay from release to the sample point; zero means no sample.
  function automatic us_cnt_t samp_us(slot_e k);
    case (k)
      SL_RESET: return us_cnt_t'(RST_SAMP_US);
      SL_READ:  return us_cnt_t'(RD_SAMP_US);
      default:  return '0;
    endcase
  endfunction

  // Released time after the sample (or after release when unsampled).
  function automatic us_cnt_t tail_us(slot_e k);
    case (k)
      SL_RESET: return us_cnt_t'(RST_TAIL_US);
      SL_W1:    return us_cnt_t'(W1_TAIL_US);
      SL_W0:    return us_cnt_t'(W0_TAIL_US);
      default:  return us_cnt_t'(RD_TAIL_US);
    endcase
  endfunction

endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_n;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_comb begin
    if (clr || tick) cnt_n = '0;
    else             cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  // Reset to the released (pulled-up) level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '1;
    else        ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
  import ow_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  start,
  input  slot_e kind,
  input  logic  line_s,
  output logic  drive_low,
  output logic  smp_valid,
  output logic  smp_val,
  output logic  slot_done
);
  typedef enum logic [1:0] {E_IDLE, E_LOW, E_REL, E_TAIL} eng_st_e;

  eng_st_e st_q, st_n;
  us_cnt_t cnt_q, cnt_n;
  us_cnt_t lim;
  slot_e   kind_q, kind_n;
  logic    drv_q, drv_n;
  logic    sv_q, sv_n;
  logic    sd_q, sd_n;
  logic    fin_q, fin_n;
  logic    last;

  always_comb begin
    case (st_q)
      E_LOW:   lim = low_us(kind_q);
      E_REL:   lim = samp_us(kind_q);
      default: lim = tail_us(kind_q);
    endcase
  end

  assign last = (cnt_q == lim - 1'b1);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    kind_n = kind_q;
    drv_n  = drv_q;
    sv_n   = 1'b0;
    sd_n   = sd_q;
    fin_n  = 1'b0;
    case (st_q)
      E_IDLE: begin
        if (start) begin
          st_n   = E_LOW;
          cnt_n  = '0;
          kind_n = kind;
          drv_n  = 1'b1;
        end
      end
      E_LOW: begin
        if (tick) begin
          if (last) begin
            drv_n = 1'b0;
            cnt_n = '0;
            st_n  = (samp_us(kind_q) != '0) ? E_REL : E_TAIL;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      E_REL: begin
        if (tick) begin
          if (last) begin
            sv_n  = 1'b1;
            sd_n  = line_s;
            cnt_n = '0;
            st_n  = E_TAIL;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        if (tick) begin
          if (last) begin
            fin_n = 1'b1;
            cnt_n = '0;
            st_n  = E_IDLE;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      cnt_q  <= '0;
      kind_q <= SL_RESET;
      drv_q  <= 1'b0;
      sv_q   <= 1'b0;
      sd_q   <= 1'b1;
      fin_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      kind_q <= kind_n;
      drv_q  <= drv_n;
      sv_q   <= sv_n;
      sd_q   <= sd_n;
      fin_q  <= fin_n;
    end
  end

  assign drive_low = drv_q;
  assign smp_valid = sv_q;
  assign smp_val   = sd_q;
  assign slot_done = fin_q;
endmodule

// File: rtl/ow_ctrl.sv
module ow_ctrl
  import ow_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [7:0]  cmd_data,
  input  logic        slot_done,
  input  logic        smp_valid,
  input  logic        smp_val,
  output logic        slot_start,
  output slot_e       slot_kind,
  output logic        busy,
  output logic        done,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        presence,
  output logic [7:0]  id_family,
  output logic [47:0] id_serial,
  output logic [7:0]  id_check
);
  typedef enum logic [1:0] {C_IDLE, C_RST, C_WR, C_RD} ctl_st_e;

  ctl_st_e    st_q, st_n;
  logic       rom_q, rom_n;
  logic [2:0] bit_q, bit_n;
  logic [2:0] byte_q, byte_n;
  logic [7:0] sh_q, sh_n;
  slot_e      kind_q, kind_n;
  logic       start_q, start_n;
  logic       done_q, done_n;
  logic       rdv_q, rdv_n;
  logic [7:0] rdd_q, rdd_n;
  logic       pres_q, pres_n;
  logic [7:0] fam_q, chk_q;
  logic       byte_end;

  // The final slot of a received byte has completed; sh_q holds the byte.
  assign byte_end = (st_q == C_RD) && slot_done && (bit_q == 3'd7);

  always_comb begin
    st_n    = st_q;
    rom_n   = rom_q;
    bit_n   = bit_q;
    byte_n  = byte_q;
    sh_n    = sh_q;
    kind_n  = kind_q;
    start_n = 1'b0;
    done_n  = 1'b0;
    rdv_n   = 1'b0;
    rdd_n   = rdd_q;
    pres_n  = pres_q;
    case (st_q)
      C_IDLE: begin
        if (cmd_valid) begin
          start_n = 1'b1;
          bit_n   = '0;
          byte_n  = '0;
          rom_n   = 1'b0;
          case (ow_op_e'(cmd_op))
            OP_RESET: begin
              st_n   = C_RST;
              kind_n = SL_RESET;
            end
            OP_WRITE: begin
              st_n   = C_WR;
              sh_n   = cmd_data;
              kind_n = cmd_data[0] ? SL_W1 : SL_W0;
            end
            OP_READ: begin
              st_n   = C_RD;
              kind_n = SL_READ;
            end
            default: begin
              st_n   = C_RST;
              rom_n  = 1'b1;
              kind_n = SL_RESET;
            end
          endcase
        end
      end
      C_RST: begin
        if (smp_valid) pres_n = ~smp_val;
        if (slot_done) begin
          if (rom_q) begin
            st_n    = C_WR;
            sh_n    = ROM_READ_CMD;
            bit_n   = '0;
            kind_n  = ROM_READ_CMD[0] ? SL_W1 : SL_W0;
            start_n = 1'b1;
          end else begin
            st_n   = C_IDLE;
            done_n = 1'b1;
          end
        end
      end
      C_WR: begin
        if (slot_done) begin
          if (bit_q == 3'd7) begin
            if (rom_q) begin
              st_n    = C_RD;
              bit_n   = '0;
              byte_n  = '0;
              kind_n  = SL_READ;
              start_n = 1'b1;
            end else begin
              st_n   = C_IDLE;
              done_n = 1'b1;
            end
          end else begin
            bit_n   = bit_q + 1'b1;
            sh_n    = {1'b0, sh_q[7:1]};
            kind_n  = sh_q[1] ? SL_W1 : SL_W0;
            start_n = 1'b1;
          end
        end
      end
      default: begin
        if (smp_valid) sh_n = {smp_val, sh_q[7:1]};
        if (slot_done) begin
          if (bit_q == 3'd7) begin
            if (rom_q && (byte_q != 3'(ROM_LEN - 1))) begin
              byte_n  = byte_q + 1'b1;
              bit_n   = '0;
              start_n = 1'b1;
            end else begin
              st_n   = C_IDLE;
              done_n = 1'b1;
              if (!rom_q) begin
                rdv_n = 1'b1;
                rdd_n = sh_q;
              end
            end
          end else begin
            bit_n   = bit_q + 1'b1;
            start_n = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= C_IDLE;
      rom_q   <= 1'b0;
      bit_q   <= '0;
      byte_q  <= '0;
      sh_q    <= '0;
      kind_q  <= SL_RESET;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
      pres_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      rom_q   <= rom_n;
      bit_q   <= bit_n;
      byte_q  <= byte_n;
      sh_q    <= sh_n;
      kind_q  <= kind_n;
      start_q <= start_n;
      done_q  <= done_n;
      rdv_q   <= rdv_n;
      rdd_q   <= rdd_n;
      pres_q  <= pres_n;
    end
  end

  // Family and check bytes: first and last of the identity sequence.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fam_q <= '0;
      chk_q <= '0;
    end else begin
      if (byte_end && rom_q && (byte_q == 3'd0))                 fam_q <= sh_q;
      if (byte_end && rom_q && (byte_q == 3'(ROM_LEN - 1)))      chk_q <= sh_q;
    end
  end

  // One capture register per serial byte.
  for (genvar g = 0; g < ID_BYTES; g++) begin : g_serial
    logic       cap_en;
    logic [7:0] cap_q;
    assign cap_en = byte_end && rom_q && (byte_q == 3'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_q <= '0;
      else if (cap_en) cap_q <= sh_q;
    end
    assign id_serial[g*8 +: 8] = cap_q;
  end

  assign slot_start = start_q;
  assign slot_kind  = kind_q;
  assign busy       = (st_q != C_IDLE);
  assign done       = done_q;
  assign rd_valid   = rdv_q;
  assign rd_data    = rdd_q;
  assign presence   = pres_q;
  assign id_family  = fam_q;
  assign id_check   = chk_q;
endmodule

// File: rtl/ow_master.sv
module ow_master
  import ow_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [7:0]  cmd_data,
  output logic        busy,
  output logic        done,
  input  logic        ow_in,
  output logic        ow_drive_low,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        presence,
  output logic [7:0]  id_family,
  output logic [47:0] id_serial,
  output logic [7:0]  id_check
);
  logic  tick;
  logic  line_s;
  logic  slot_start;
  slot_e slot_kind;
  logic  slot_done;
  logic  smp_valid;
  logic  smp_val;

  ow_tick_gen #(.DIV(CLK_MHZ)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (slot_start),
    .tick (tick)
  );

  ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ow_in),
    .q    (line_s)
  );

  ow_slot_engine u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .start    (slot_start),
    .kind     (slot_kind),
    .line_s   (line_s),
    .drive_low(ow_drive_low),
    .smp_valid(smp_valid),
    .smp_val  (smp_val),
    .slot_done(slot_done)
  );

  ow_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .slot_done (slot_done),
    .smp_valid (smp_valid),
    .smp_val   (smp_val),
    .slot_start(slot_start),
    .slot_kind (slot_kind),
    .busy      (busy),
    .done      (done),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .presence  (presence),
    .id_family (id_family),
    .id_serial (id_serial),
    .id_check  (id_check)
  );
endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk #(
  parameter int unsigned CLK_MHZ = 50
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic rd_valid,
  input logic ow_drive_low
);
  localparam int unsigned MAX_LOW = 480 * CLK_MHZ;

  int unsigned low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_run_q <= 0;
    else if (ow_drive_low) low_run_q <= low_run_q + 1;
    else                   low_run_q <= 0;
  end

  assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ow_drive_low |-> busy);

  assert_low_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    low_run_q <= MAX_LOW);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_rdv_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> done);

  assert_start_needs_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));
endmodule

bind ow_master ow_master_chk #(.CLK_MHZ(CLK_MHZ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .busy        (busy),
  .done        (done),
  .rd_valid    (rd_valid),
  .ow_drive_low(ow_drive_low)
);

// File: tb/sim_ow_master.sv
module sim_ow_master;
  localparam int US = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [7:0]  cmd_data = 8'd0;
  logic        busy, done, rd_valid, presence, drv;
  logic [7:0]  rd_data, id_family, id_check;
  logic [47:0] id_serial;
  logic        dev_low = 1'b0;
  logic        ow_in;

  assign ow_in = ~(drv | dev_low);

  always #5 clk = ~clk;

  ow_master #(.CLK_MHZ(US)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .busy(busy), .done(done), .ow_in(ow_in),
    .ow_drive_low(drv), .rd_valid(rd_valid), .rd_data(rd_data),
    .presence(presence), .id_family(id_family), .id_serial(id_serial),
    .id_check(id_check)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- responder model ----------------
  bit dev_present = 1'b0;
  int pres_a = 15, pres_b = 200;
  int dev_skip = 0;
  int slot_no = 0;
  int lw = 0, rel = 0, win_a = 0, win_b = 0;
  int widths[$];
  bit wbits[$];
  bit txq[$];

  always @(negedge clk) begin
    if (!rst_n) begin
      lw = 0; dev_low = 1'b0; win_b = 0;
    end else begin
      if (drv) lw++;
      else if (lw != 0) begin
        widths.push_back(lw);
        rel = 0;
        if (lw >= 300 * US) begin
          slot_no = 0;
          win_a = pres_a * US;
          win_b = dev_present ? pres_b * US : 0;
        end else begin
          slot_no++;
          wbits.push_back(lw <= 15 * US);
          win_a = 0;
          win_b = 0;
          if (slot_no > dev_skip && txq.size() > 0) begin
            if (!txq.pop_front()) win_b = 15 * US;
          end
        end
        lw = 0;
      end
      dev_low = (!drv) && (rel >= win_a) && (rel < win_b);
      rel++;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    int          op;
    logic [7:0]  data;
    logic        pres;
    logic [7:0]  fam;
    logic [47:0] ser;
    logic [7:0]  crc;
  } exp_t;

  exp_t sbq[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R8", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(!busy, "R7", "busy at done", 64'(busy), 64'd0);
        case (e.op)
          0: chk(presence == e.pres, "R3", "presence", 64'(presence), 64'(e.pres));
          1: chk(!rd_valid, "R4", "rd_valid on write", 64'(rd_valid), 64'd0);
          2: begin
            chk(rd_valid, "R5", "rd_valid", 64'(rd_valid), 64'd1);
            chk(rd_data == e.data, "R5", "rd_data", 64'(rd_data), 64'(e.data));
          end
          default: begin
            chk(presence == e.pres, "R6", "fetch presence", 64'(presence), 64'(e.pres));
            chk(id_family == e.fam, "R6", "family", 64'(id_family), 64'(e.fam));
            chk(id_serial == e.ser, "R6", "serial", 64'(id_serial), 64'(e.ser));
            chk(id_check == e.crc, "R6", "check byte", 64'(id_check), 64'(e.crc));
            chk(!rd_valid, "R6", "rd_valid in fetch", 64'(rd_valid), 64'd0);
          end
        endcase
      end
    end
  end

  // After done, the next negedge must show done low again (R7).
  always @(negedge clk) begin
    if (rst_n && done) begin
      @(negedge clk);
      chk(!done, "R7", "done width", 64'(done), 64'd0);
    end
  end

  int busy_cyc;

  task automatic send(input int op, input logic [7:0] data, input exp_t e,
                      input bit poke);
    e.op = op;
    sbq.push_back(e);
    widths.delete();
    wbits.delete();
    while (busy) @(negedge clk);
    cmd_op = 2'(op);
    cmd_data = data;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_cyc = 0;
    while (busy) begin
      busy_cyc++;
      if (poke && busy_cyc == 50) begin
        // R8: a second command mid-flight must be ignored
        cmd_op = 2'd1; cmd_data = 8'h00; cmd_valid = 1'b1;
      end
      if (poke && busy_cyc == 53) cmd_valid = 1'b0;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic load_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) txq.push_back(b[i]);
  endtask

  exp_t e0;
  logic [47:0] ser_exp;
  logic [7:0] ser_b[6];
  logic [7:0] rebuilt;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired", 64'd1, 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    e0 = '{op: 0, data: 8'h00, pres: 1'b0, fam: 8'h00, ser: 48'h0, crc: 8'h00};
    repeat (4) @(negedge clk);
    // R1: state while and just after reset
    chk(!drv && !busy && !done && !rd_valid && !presence, "R1", "reset outputs",
        64'({drv, busy, done, rd_valid, presence}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 0 && id_family == 0 && id_serial == 0 && id_check == 0, "R1",
        "reset data", 64'(id_serial), 64'd0);
    chk(!drv && !busy, "R1", "idle after reset", 64'({drv, busy}), 64'd0);

    // R2/R3: reset with a responder present
    dev_present = 1'b1; pres_a = 15; pres_b = 200;
    e0.pres = 1'b1;
    send(0, 8'h00, e0, 1'b0);
    chk(busy_cyc == 960 * US + 2, "R2", "reset busy cycles", 64'(busy_cyc), 64'(960 * US + 2));
    chk(widths.size() == 1 && widths[0] == 480 * US, "R2", "reset low width",
        64'(widths.size() > 0 ? widths[0] : 0), 64'(480 * US));

    // R3: nobody on the line
    dev_present = 1'b0;
    e0.pres = 1'b0;
    send(0, 8'h00, e0, 1'b0);

    // R3: responder lets go before the sample point -> absent
    dev_present = 1'b1; pres_a = 15; pres_b = 60;
    send(0, 8'h00, e0, 1'b0);

    // R3: responder pulls only from 65 us on -> present at 70 us
    pres_a = 65; pres_b = 100;
    e0.pres = 1'b1;
    send(0, 8'h00, e0, 1'b0);

    // R4: write 0xA5, bit 0 first
    send(1, 8'hA5, e0, 1'b0);
    chk(widths.size() == 8, "R4", "write slot count", 64'(widths.size()), 64'd8);
    rebuilt = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (i < widths.size()) begin
        chk(widths[i] == (8'hA5 >> i & 1 ? 6 * US : 60 * US), "R4", "write low width",
            64'(widths[i]), 64'((8'hA5 >> i & 1) ? 6 * US : 60 * US));
        rebuilt[i] = wbits[i];
      end
    end
    chk(rebuilt == 8'hA5, "R4", "bit order on wire", 64'(rebuilt), 64'hA5);

    // R5: read bytes of several patterns
    dev_skip = 0;
    load_byte(8'h3C);
    e0.data = 8'h3C;
    send(2, 8'h00, e0, 1'b0);
    chk(widths.size() == 8 && widths[0] == 6 * US, "R5", "read slot width",
        64'(widths.size() > 0 ? widths[0] : 0), 64'(6 * US));
    e0.data = 8'hFF;
    send(2, 8'h00, e0, 1'b0);
    load_byte(8'h00);
    e0.data = 8'h00;
    send(2, 8'h00, e0, 1'b0);
    load_byte(8'h81);
    e0.data = 8'h81;
    send(2, 8'h00, e0, 1'b0);

    // R8: a command during a read is ignored
    load_byte(8'h96);
    e0.data = 8'h96;
    send(2, 8'h00, e0, 1'b1);
    chk(widths.size() == 8, "R8", "slots after ignored cmd", 64'(widths.size()), 64'd8);
    for (int i = 0; i < 8; i++)
      if (i < widths.size())
        chk(widths[i] == 6 * US, "R8", "no write slot inserted", 64'(widths[i]), 64'(6 * US));

    // R6: identity fetch
    dev_present = 1'b1; pres_a = 15; pres_b = 200;
    dev_skip = 8;
    txq.delete();
    ser_b = '{8'hA1, 8'h5B, 8'h3C, 8'hE7, 8'h02, 8'h99};
    load_byte(8'h01);
    ser_exp = '0;
    for (int i = 0; i < 6; i++) begin
      load_byte(ser_b[i]);
      ser_exp[i*8 +: 8] = ser_b[i];
    end
    load_byte(8'h4D);
    e0.pres = 1'b1; e0.fam = 8'h01; e0.ser = ser_exp; e0.crc = 8'h4D;
    send(3, 8'h00, e0, 1'b0);
    chk(widths.size() == 73, "R6", "fetch slot count", 64'(widths.size()), 64'd73);
    rebuilt = 8'h00;
    for (int i = 0; i < 8; i++) if (i < wbits.size()) rebuilt[i] = wbits[i];
    chk(rebuilt == 8'h33, "R6", "fetch command byte", 64'(rebuilt), 64'h33);
    chk(widths.size() > 0 && widths[0] == 480 * US, "R6", "fetch reset width",
        64'(widths.size() > 0 ? widths[0] : 0), 64'(480 * US));

    repeat (10) @(negedge clk);
    chk(sbq.size() == 0, "R7", "pending results", 64'(sbq.size()), 64'd0);
    chk(!drv && !busy, "R9", "idle line released", 64'({drv, busy}), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule